// File: doc/BRIEF.md
# Frame-Synchronised Subaddressed Control Register Bank

This block holds the configuration registers of a serial-bus slave. It sits behind a byte-level front end. That front end reports a bus start, a bus stop and each received byte. For every byte it gets back an acknowledge decision, one cycle later. A write transfer begins with the device address byte. The byte after it selects one of sixteen 8-bit subaddresses, and every byte after that is data.

A mode bit in the bank's own control register picks how data is applied. In immediate mode each data byte lands in its live register at once, and the subaddress steps forward, wrapping from 0xF to 0x0. In frame-synchronised mode a data byte goes to a shadow copy and marks a commit as pending. The subaddress holds still. At the next vertical-blanking strobe every shadow register is copied into its live register. Until that copy happens, further data bytes are refused with no acknowledge. Writes to the control register itself always take effect at once, so software can always leave buffered mode.

The live registers appear on one flat output bus. Subaddress i occupies bits 8i+7 down to 8i.

Top module: `regBank`

## Requirements
- R1: After reset every live register reads 0x00, no commit is pending, and ackValid is low.
- R2: Every received byte gives a one-cycle ackValid pulse on the following cycle. The first byte after a start is the device address and is acknowledged. The second byte is the subaddress. A byte received outside a transfer gets ackOut=0 and has no effect.
- R3: A subaddress byte above 0x0F gets ackOut=0. Every later byte of that transfer also gets ackOut=0 and changes no register.
- R4: With the mode bit at 0, an acknowledged data byte appears in its live register on the same edge that registers the acknowledge.
- R5: With the mode bit at 0, the subaddress advances by one after each data byte and wraps from 0xF to 0x0.
- R6: Subaddresses 0xB, 0xE and 0xF are acknowledged and take part in auto-increment, but they always read 0x00.
- R7: The mode bit is bit 3 of subaddress 0xA. With it at 1, a data byte to any other subaddress leaves the live register unchanged, sets the pending flag, and does not advance the subaddress.
- R8: While a commit is pending, data bytes to any subaddress except 0xA get ackOut=0 and are dropped. A vertical-blanking strobe copies all shadow values to the live registers and clears the pending flag on the same edge. Values written earlier in immediate mode survive the copy.
- R9: A data byte to subaddress 0xA is acknowledged and takes effect at once in either mode, even while a commit is pending. Whether the subaddress then advances depends on the mode bit as it was before that byte.
- R10: A stop ends the transfer, and later bytes are refused until the next start. A repeated start restarts the sequence, so its next byte is treated as a device address again.
- R11: A vertical-blanking strobe with no commit pending changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busStart | input | 1 | Start or repeated-start strobe from the front end |
| busStop | input | 1 | Stop strobe from the front end |
| rxValid | input | 1 | A received byte is present on rxByte |
| rxByte | input | 8 | Received byte |
| vblankStrobe | input | 1 | One-cycle pulse marking vertical blanking |
| ackValid | output | 1 | Acknowledge decision is valid (one cycle after rxValid) |
| ackOut | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| commitPending | output | 1 | A buffered write awaits vertical blanking |
| regFile | output | 128 | Live registers, subaddress i at bits 8i+7:8i |

## Verification
Each pattern is matched against a behavioural model every cycle.

- A run of data bytes starting at 0x3, and a second run starting at 0xD, show whether auto-increment works and wraps from 0xF to 0x0. The second run passes through the reserved slots, so it also shows that they are acknowledged but store nothing.
- An out-of-range subaddress followed by data shows that the whole rest of the transfer is dropped, not only the offending byte.
- In buffered mode, three patterns are checked:
  - a byte sent while a commit is pending;
  - a control write sent while a commit is pending;
  - two bytes in one transfer split by a blanking strobe, which shows that the subaddress is frozen in this mode and that an older immediate write survives the commit.
- A restart directly followed by a would-be subaddress shows that the sequence counter really resets.

// File: rtl/regBankPkg.sv
package regBankPkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 1 << ADDR_W;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_SUB,
    S_DATA,
    S_DROP
  } xferState_t;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic              wrLive;    // immediate write: live and shadow
    logic              wrShadow;  // buffered write: shadow only
    logic              commit;    // copy shadow to live
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
  } bankStrobe_t;
endpackage

// File: rtl/regBankCtrl.sv
module regBankCtrl
  import regBankPkg::*;
#(
  parameter logic [ADDR_W-1:0]   CTRL_SUB  = 4'hA,
  parameter logic [NUM_REGS-1:0] RSVD_MASK = 16'hC800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busStart,
  input  logic              busStop,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              vblankStrobe,
  input  logic              bufEn,
  output bankStrobe_t       strb,
  output logic              ackValid,
  output logic              ackOut,
  output logic              commitPending
);
  xferState_t        stateQ, stateD;
  logic [ADDR_W-1:0] ptrQ, ptrD;
  logic              pendQ, pendD;
  logic              ackQ, ackD, ackVQ, ackVD;
  logic              byteIn;

  assign byteIn = rxValid && !busStart && !busStop;

  always_comb begin
    stateD      = stateQ;
    ptrD        = ptrQ;
    pendD       = pendQ;
    ackD        = 1'b0;
    ackVD       = byteIn;
    strb        = '0;
    strb.wrAddr = ptrQ;
    strb.wrData = rxByte;
    if (vblankStrobe && pendQ) begin
      strb.commit = 1'b1;
      pendD       = 1'b0;
    end
    if (busStart) begin
      stateD = S_ADDR;
    end else if (busStop) begin
      stateD = S_IDLE;
    end else if (rxValid) begin
      unique case (stateQ)
        S_ADDR: begin
          ackD   = 1'b1;
          stateD = S_SUB;
        end
        S_SUB: begin
          if (rxByte[DATA_W-1:ADDR_W] != '0) begin
            stateD = S_DROP;
          end else begin
            ackD   = 1'b1;
            ptrD   = rxByte[ADDR_W-1:0];
            stateD = S_DATA;
          end
        end
        S_DATA: begin
          if (ptrQ == CTRL_SUB) begin
            ackD        = 1'b1;
            strb.wrLive = 1'b1;
            if (!bufEn) ptrD = ptrQ + 1'b1;
          end else if (!pendQ) begin
            ackD = 1'b1;
            if (!RSVD_MASK[ptrQ]) begin
              if (bufEn) begin
                strb.wrShadow = 1'b1;
                pendD         = 1'b1;
              end else begin
                strb.wrLive = 1'b1;
              end
            end
            if (!bufEn) ptrD = ptrQ + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      ptrQ   <= '0;
      pendQ  <= 1'b0;
      ackQ   <= 1'b0;
      ackVQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      ptrQ   <= ptrD;
      pendQ  <= pendD;
      ackQ   <= ackD;
      ackVQ  <= ackVD;
    end
  end

  assign ackValid      = ackVQ;
  assign ackOut        = ackQ;
  assign commitPending = pendQ;

  p_ack_follows_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    ackVQ |-> $past(rxValid));

  p_drop_refused_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_DROP && byteIn) |=> (ackVQ && !ackQ));

  p_pend_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendQ) |-> $past(strb.wrShadow));

  p_frozen_ptr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_DATA && byteIn && bufEn) |=> $stable(ptrQ));

  p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendQ) |-> $past(vblankStrobe));
endmodule

// File: rtl/regBankData.sv
module regBankData
  import regBankPkg::*;
#(
  parameter logic [ADDR_W-1:0]   CTRL_SUB  = 4'hA,
  parameter int                  BUF_BIT   = 3,
  parameter logic [NUM_REGS-1:0] RSVD_MASK = 16'hC800
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bankStrobe_t                strb,
  output logic [NUM_REGS*DATA_W-1:0] regFile,
  output logic                       bufEn
);
  localparam int CTRL_IDX = int'(CTRL_SUB);

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    if (RSVD_MASK[gi]) begin : g_rsvd
      assign regFile[gi*DATA_W +: DATA_W] = '0;
    end else begin : g_store
      localparam bit IS_CTRL = (gi == CTRL_IDX);
      logic [DATA_W-1:0] liveQ, shadowQ;
      logic              hit;
      assign hit = (strb.wrAddr == ADDR_W'(gi));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          liveQ   <= '0;
          shadowQ <= '0;
        end else if (strb.wrLive && hit) begin
          liveQ   <= strb.wrData;
          shadowQ <= strb.wrData;
        end else begin
          if (strb.wrShadow && hit) shadowQ <= strb.wrData;
          if (strb.commit && !IS_CTRL) liveQ <= shadowQ;
        end
      end
      assign regFile[gi*DATA_W +: DATA_W] = liveQ;
    end
  end

  assign bufEn = regFile[CTRL_IDX*DATA_W + BUF_BIT];

  p_live_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrLive && !strb.commit) |=> $stable(regFile));
endmodule

// File: rtl/regBank.sv
module regBank
  import regBankPkg::*;
#(
  parameter logic [ADDR_W-1:0]   CTRL_SUB  = 4'hA,
  parameter int                  BUF_BIT   = 3,
  parameter logic [NUM_REGS-1:0] RSVD_MASK = 16'hC800
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busStart,
  input  logic                       busStop,
  input  logic                       rxValid,
  input  logic [DATA_W-1:0]          rxByte,
  input  logic                       vblankStrobe,
  output logic                       ackValid,
  output logic                       ackOut,
  output logic                       commitPending,
  output logic [NUM_REGS*DATA_W-1:0] regFile
);
  bankStrobe_t strb;
  logic        bufEn;

  regBankCtrl #(.CTRL_SUB(CTRL_SUB), .RSVD_MASK(RSVD_MASK)) u_ctrl (
    .clk(clk), .rstN(rstN), .busStart(busStart), .busStop(busStop),
    .rxValid(rxValid), .rxByte(rxByte), .vblankStrobe(vblankStrobe),
    .bufEn(bufEn), .strb(strb), .ackValid(ackValid), .ackOut(ackOut),
    .commitPending(commitPending)
  );

  regBankData #(.CTRL_SUB(CTRL_SUB), .BUF_BIT(BUF_BIT), .RSVD_MASK(RSVD_MASK)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .regFile(regFile), .bufEn(bufEn)
  );
endmodule

// File: tb/regBank_bench.sv
module regBank_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busStart = 1'b0, busStop = 1'b0, rxValid = 1'b0, vblankStrobe = 1'b0;
  logic [7:0]   rxByte = 8'h00;
  logic         ackValid, ackOut, commitPending;
  logic [127:0] regFile;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  string curTag = "R1";

  always #2 clk = ~clk;  // 250 MHz

  regBank u_regBank (
    .clk(clk), .rstN(rstN), .busStart(busStart), .busStop(busStop),
    .rxValid(rxValid), .rxByte(rxByte), .vblankStrobe(vblankStrobe),
    .ackValid(ackValid), .ackOut(ackOut), .commitPending(commitPending),
    .regFile(regFile)
  );

  // Behavioural reference model
  int mLive[16];
  int mShadow[16];
  bit mPend = 0, mAckV = 0, mAck = 0;
  int mSt = 0;  // 0 none, 1 address, 2 subaddress, 3 data, 4 dropped
  int mPtr = 0;

  function automatic bit isRsvd(int i);
    return (i == 11) || (i == 14) || (i == 15);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) begin mLive[i] = 0; mShadow[i] = 0; end
      mPend = 0; mAckV = 0; mAck = 0; mSt = 0; mPtr = 0;
    end else begin
      bit oldPend;
      bit oldBuf;
      oldPend = mPend;
      oldBuf  = mLive[10][3];
      mAckV = 0; mAck = 0;
      if (busStart) mSt = 1;
      else if (busStop) mSt = 0;
      else if (rxValid) begin
        mAckV = 1;
        if (mSt == 1) begin mAck = 1; mSt = 2; end
        else if (mSt == 2) begin
          if (rxByte > 8'h0F) mSt = 4;
          else begin mAck = 1; mPtr = rxByte; mSt = 3; end
        end else if (mSt == 3) begin
          if (mPtr == 10) begin
            mAck = 1; mLive[10] = rxByte; mShadow[10] = rxByte;
            if (!oldBuf) mPtr = (mPtr + 1) % 16;
          end else if (!oldPend) begin
            mAck = 1;
            if (!isRsvd(mPtr)) begin
              if (oldBuf) begin mShadow[mPtr] = rxByte; mPend = 1; end
              else begin mLive[mPtr] = rxByte; mShadow[mPtr] = rxByte; end
            end
            if (!oldBuf) mPtr = (mPtr + 1) % 16;
          end
        end
      end
      if (vblankStrobe && oldPend) begin
        for (int i = 0; i < 16; i++)
          if (i != 10 && !isRsvd(i)) mLive[i] = mShadow[i];
        mPend = 0;
      end
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int i = 0; i < 16; i++)
        if (regFile[i*8 +: 8] != mLive[i][7:0])
          check(0, curTag, $sformatf("model reg %0d", i), regFile[i*8 +: 8], mLive[i]);
      check(commitPending == mPend, curTag, "model pending", commitPending, mPend);
      check(ackValid == mAckV, curTag, "model ackValid", ackValid, mAckV);
      check(ackOut == mAck, curTag, "model ackOut", ackOut, mAck);
    end
  end

  task automatic pulseStart();
    @(negedge clk); busStart = 1'b1; @(negedge clk); busStart = 1'b0;
  endtask
  task automatic pulseStop();
    @(negedge clk); busStop = 1'b1; @(negedge clk); busStop = 1'b0;
  endtask
  task automatic pulseVblank();
    @(negedge clk); vblankStrobe = 1'b1; @(negedge clk); vblankStrobe = 1'b0;
  endtask
  task automatic sendByte(logic [7:0] b, bit expAck, string tag);
    @(negedge clk); rxValid = 1'b1; rxByte = b;
    @(negedge clk); rxValid = 1'b0;
    check(ackValid == 1'b1, tag, "ackValid", ackValid, 1);
    check(ackOut == expAck, tag, $sformatf("ack for byte %0h", b), ackOut, expAck);
  endtask
  task automatic chkReg(int idx, logic [7:0] exp, string tag);
    check(regFile[idx*8 +: 8] == exp, tag, $sformatf("reg %0d", idx), regFile[idx*8 +: 8], exp);
  endtask
  task automatic chkPend(bit exp, string tag);
    check(commitPending == exp, tag, "pending", commitPending, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(regFile == '0, "R1", "regs in reset", 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(regFile == '0, "R1", "regs after reset", 0, 0);
    chkPend(0, "R1");
    check(ackValid == 1'b0, "R1", "ackValid after reset", ackValid, 0);

    curTag = "R2";
    sendByte(8'h21, 0, "R2");               // no transfer open
    pulseStart();
    sendByte(8'h40, 1, "R2");               // device address
    sendByte(8'h03, 1, "R2");               // subaddress
    curTag = "R4";
    sendByte(8'h11, 1, "R4");
    chkReg(3, 8'h11, "R4");
    curTag = "R5";
    sendByte(8'h22, 1, "R5");
    chkReg(4, 8'h22, "R5");
    pulseStop();

    curTag = "R6";
    pulseStart();
    sendByte(8'h40, 1, "R2");
    sendByte(8'h0D, 1, "R6");
    sendByte(8'hAA, 1, "R6");
    sendByte(8'hBB, 1, "R6");               // 0xE reserved
    sendByte(8'hCC, 1, "R6");               // 0xF reserved
    sendByte(8'hDD, 1, "R5");               // wrapped to 0x0
    chkReg(13, 8'hAA, "R5");
    chkReg(14, 8'h00, "R6");
    chkReg(15, 8'h00, "R6");
    chkReg(0, 8'hDD, "R5");
    pulseStop();

    curTag = "R3";
    pulseStart();
    sendByte(8'h40, 1, "R3");
    sendByte(8'h10, 0, "R3");
    sendByte(8'h55, 0, "R3");
    sendByte(8'h56, 0, "R3");
    chkReg(0, 8'hDD, "R3");
    pulseStart();
    sendByte(8'h40, 1, "R6");
    sendByte(8'h0B, 1, "R6");
    sendByte(8'h77, 1, "R6");
    chkReg(11, 8'h00, "R6");
    chkReg(12, 8'h00, "R6");                // advanced past 0xB, wrote 0xC? no: only one byte
    pulseStop();

    curTag = "R11";
    pulseVblank();
    chkReg(3, 8'h11, "R11");
    chkReg(4, 8'h22, "R11");

    curTag = "R7";
    pulseStart();
    sendByte(8'h40, 1, "R9");
    sendByte(8'h0A, 1, "R9");
    sendByte(8'h08, 1, "R9");               // buffered mode on
    chkReg(10, 8'h08, "R9");
    pulseStop();
    pulseStart();
    sendByte(8'h40, 1, "R7");
    sendByte(8'h05, 1, "R7");
    sendByte(8'h66, 1, "R7");
    chkReg(5, 8'h00, "R7");
    chkPend(1, "R7");
    curTag = "R8";
    sendByte(8'h67, 0, "R8");               // refused while pending
    chkPend(1, "R8");
    curTag = "R10";
    pulseStart();                           // repeated start
    sendByte(8'h40, 1, "R10");
    sendByte(8'h0A, 1, "R9");
    sendByte(8'h08, 1, "R9");               // control accepted while pending
    chkPend(1, "R9");
    curTag = "R8";
    pulseVblank();
    chkReg(5, 8'h66, "R8");
    chkPend(0, "R8");
    chkReg(3, 8'h11, "R8");                 // older immediate write survives
    chkReg(10, 8'h08, "R8");

    curTag = "R7";
    pulseStart();
    sendByte(8'h40, 1, "R7");
    sendByte(8'h06, 1, "R7");
    sendByte(8'h01, 1, "R7");
    pulseVblank();
    sendByte(8'h02, 1, "R7");               // same subaddress, no advance
    pulseVblank();
    chkReg(6, 8'h02, "R7");
    chkReg(7, 8'h00, "R7");
    pulseStop();

    curTag = "R9";
    pulseStart();
    sendByte(8'h40, 1, "R9");
    sendByte(8'h0A, 1, "R9");
    sendByte(8'h00, 1, "R9");               // back to immediate
    pulseStop();
    pulseStart();
    sendByte(8'h40, 1, "R9");
    sendByte(8'h07, 1, "R9");
    sendByte(8'h99, 1, "R9");
    chkReg(7, 8'h99, "R9");
    chkPend(0, "R9");
    pulseStop();

    curTag = "R10";
    sendByte(8'h03, 0, "R10");              // after stop: refused
    pulseStart();
    sendByte(8'h03, 1, "R10");              // taken as device address
    sendByte(8'h02, 1, "R10");              // subaddress
    sendByte(8'h12, 1, "R10");
    chkReg(2, 8'h12, "R10");
    chkReg(3, 8'h11, "R10");
    pulseStop();

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule